// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a processor tick timer. It holds two 32-bit registers that software can read and write. The control register holds a period, an interrupt-enable bit, a sticky interrupt-pending bit and a two-bit operating mode. The count register advances by one on every cycle where the tick-enable input is high and counting is active. A tick-enable pulse is nominally one tick of a 20 MHz (50 ns) time base. That prescaler sits outside the block.

A match happens on a tick cycle when the low period field of the count equals the period field of the control register. All higher count bits are ignored. On a match the mode decides what the count does next:
- It is cleared in restart mode.
- It freezes in one-shot mode.
- It keeps incrementing in continuous mode.

When interrupt enable is set, a match also sets the pending bit. The interrupt output is the AND of pending and enable. Software clears pending by writing it to 0.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register and the count register both read 0x00000000, and `irq` is low.
- R2: Control register fields are: bits 27:0 period, bit 28 pending, bit 29 interrupt enable, and bits 31:30 mode (00 off, 01 restart, 10 one-shot, 11 continuous). In mode 00 the count holds its value while `tickEn` is high.
- R3: While the mode is nonzero and the timer is not halted, the count increases by exactly 1 on each cycle with `tickEn` high. It holds on cycles with `tickEn` low.
- R4: A match compares only count bits 27:0 with control bits 27:0. Count bits 31:28 do not prevent or cause a match.
- R5: A match while bit 29 is set sets bit 28. `irq` equals bit 28 AND bit 29 of the control register.
- R6: Bit 28, once set, stays set through further ticks until a control write stores 0 in it.
- R7: In restart mode (01) the count becomes 0 on the cycle after a match.
- R8: In one-shot mode (10) the count stops at the match value and stays frozen through further ticks. A control write with a nonzero mode resumes counting.
- R9: In continuous mode (11) the count increments through a match. The next match comes only after the period field wraps, at a distance of (0x0FFFFFFF - count field + 1 + period) ticks.
- R10: A count-register write in the same cycle as a tick stores the written value, and the increment is lost.
- R11: `regRdata` shows the control register when `regAddr` is 0 and the count register when `regAddr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 1 | Register select: 0 control, 1 count |
| regWe | input | 1 | Write strobe for the selected register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register |
| tickEn | input | 1 | One timer tick when high |
| irq | output | 1 | Level interrupt request (pending AND enable) |

## Verification
The timer is driven with four tick patterns:
- Short periods reached from zero in restart and one-shot modes. These separate the clear action from the freeze action.
- A count preset just below the period-field wrap, with a high count bit set, in continuous mode. This exposes any comparison that uses more than 28 bits, and any wrap distance that is off by one.
- Runs with tick-enable low and with the mode off. These show the count does not move when it should not.
- A count write on the same cycle as a tick, which tells write priority apart from increment.

A behavioural model checks both read addresses and the interrupt line on every clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } timerMode_e;

  typedef struct packed {
    logic incr;
    logic clear;
    logic setPend;
  } timerStrb_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeField,
  input  logic                ieBit,
  input  logic [PERIOD_W-1:0] periodField,
  input  logic [PERIOD_W-1:0] countField,
  input  logic                tickEn,
  input  logic                modeWr,
  input  logic [1:0]          modeWrField,
  output timerStrb_t          strb,
  output logic                haltQ
);
  timerMode_e mode;
  logic       active;
  logic       hit;

  assign mode   = timerMode_e'(modeField);
  assign active = (mode != MODE_OFF) && !haltQ && tickEn;
  assign hit    = active && (countField == periodField);

  always_comb begin
    strb         = '0;
    strb.setPend = hit && ieBit;
    if (active) begin
      if (hit) begin
        unique case (mode)
          MODE_RESTART: strb.clear = 1'b1;
          MODE_CONT:    strb.incr  = 1'b1;
          default:      strb.incr  = 1'b0;
        endcase
      end else begin
        strb.incr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ <= 1'b0;
    end else if (modeWr && (modeWrField != 2'b00)) begin
      haltQ <= 1'b0;
    end else if (hit && (mode == MODE_ONESHOT)) begin
      haltQ <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  input  timerStrb_t        strb,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic [DATA_W-1:0] modeQ,
  output logic [DATA_W-1:0] countQ
);
  localparam int PEND_BIT = PERIOD_W;
  localparam int IE_BIT   = PERIOD_W + 1;

  logic modeWr;
  logic countWr;

  assign modeWr  = regWe && !regAddr;
  assign countWr = regWe && regAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (modeWr) begin
      modeQ <= regWdata;
    end else if (strb.setPend) begin
      modeQ[PEND_BIT] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (countWr) begin
      countQ <= regWdata;
    end else if (strb.clear) begin
      countQ <= '0;
    end else if (strb.incr) begin
      countQ <= countQ + 1'b1;
    end
  end

  assign regRdata = regAddr ? countQ : modeQ;
  assign irq      = modeQ[PEND_BIT] && modeQ[IE_BIT];
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              tickEn,
  output logic              irq
);
  localparam int IE_BIT = PERIOD_W + 1;

  timerStrb_t        strb;
  logic [DATA_W-1:0] modeQ;
  logic [DATA_W-1:0] countQ;
  logic              haltQ;

  tick_timer_ctrl #(.PERIOD_W(PERIOD_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeField   (modeQ[DATA_W-1 -: 2]),
    .ieBit       (modeQ[IE_BIT]),
    .periodField (modeQ[PERIOD_W-1:0]),
    .countField  (countQ[PERIOD_W-1:0]),
    .tickEn      (tickEn),
    .modeWr      (regWe && !regAddr),
    .modeWrField (regWdata[DATA_W-1 -: 2]),
    .strb        (strb),
    .haltQ       (haltQ)
  );

  tick_timer_dp #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .strb     (strb),
    .regRdata (regRdata),
    .irq      (irq),
    .modeQ    (modeQ),
    .countQ   (countQ)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input logic              clk,
  input logic              rstN,
  input logic              regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              tickEn,
  input logic              irq,
  input logic [DATA_W-1:0] modeQ,
  input logic [DATA_W-1:0] countQ,
  input logic              haltQ
);
  localparam int PEND_BIT = PERIOD_W;
  localparam int IE_BIT   = PERIOD_W + 1;

  logic [1:0] md;
  logic       modeWr, countWr, hit;

  assign md      = modeQ[DATA_W-1 -: 2];
  assign modeWr  = regWe && !regAddr;
  assign countWr = regWe && regAddr;
  assign hit     = tickEn && (md != 2'b00) && !haltQ &&
                   (countQ[PERIOD_W-1:0] == modeQ[PERIOD_W-1:0]);

  assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (md == 2'b00 && !countWr) |=> $stable(countQ));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !countWr) |=> $stable(countQ));

  assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && modeQ[IE_BIT] && !modeWr) |=> modeQ[PEND_BIT]);

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!regAddr) |-> (irq == (regRdata[PEND_BIT] && regRdata[IE_BIT])));

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[PEND_BIT] && !modeWr) |=> modeQ[PEND_BIT]);

  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hit && md == 2'b01 && !countWr) |=> (countQ == '0));

  assert_oneshot_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hit && md == 2'b10 && !regWe) |=> ($stable(countQ) && haltQ));

  assert_cont_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && md == 2'b11 && !countWr) |=> (countQ == $past(countQ) + 1'b1));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    countWr |=> (countQ == $past(regWdata)));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWe    (regWe),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .tickEn   (tickEn),
  .irq      (irq),
  .modeQ    (modeQ),
  .countQ   (countQ),
  .haltQ    (haltQ)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regAddr = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        tickEn = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .tickEn(tickEn), .irq(irq)
  );

  // behavioural reference
  bit [31:0] refMode = 0, refCnt = 0;
  bit        refHalt = 0;

  always @(posedge clk) begin
    bit [31:0] nMode, nCnt;
    bit        nHalt, match;
    int        md;
    if (!rstN) begin
      refMode <= 0; refCnt <= 0; refHalt <= 0;
    end else begin
      md    = int'(refMode[31:30]);
      match = tickEn && md != 0 && !refHalt && refCnt[27:0] == refMode[27:0];
      nMode = refMode; nCnt = refCnt; nHalt = refHalt;
      if (tickEn && md != 0 && !refHalt) begin
        if (!match) nCnt = refCnt + 1;
        else if (md == 1) nCnt = 0;
        else if (md == 2) nHalt = 1;
        else nCnt = refCnt + 1;
      end
      if (match && refMode[29]) nMode[28] = 1;
      if (regWe && !regAddr) begin
        nMode = regWdata;
        if (regWdata[31:30] != 0) nHalt = 0;
      end
      if (regWe && regAddr) nCnt = regWdata;
      refMode <= nMode; refCnt <= nCnt; refHalt <= nHalt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model (R11 read mux, R5 irq level)
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R11 readback", regRdata, regAddr ? refCnt : refMode);
      chk("R5 irq", {31'd0, irq}, {31'd0, refMode[28] & refMode[29]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wrReg(bit a, bit [31:0] d, bit tk = 1'b0);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d; tickEn = tk;
    @(negedge clk);
    regWe = 1'b0; tickEn = 1'b0;
  endtask

  task automatic ticks(int n, bit tk = 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = tk;
    end
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic peek(bit a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    peek(0, v); chk("R1 control reset", v, 32'h0);
    peek(1, v); chk("R1 count reset", v, 32'h0);
    rstN = 1'b1;
    peek(0, v); chk("R1 irq reset", {31'd0, irq}, 32'd0);

    // R7 restart, period 3, IE set
    wrReg(0, 32'h6000_0003);
    ticks(4);
    peek(1, v); chk("R7 restart clears count", v, 32'd0);
    chk("R5 irq after match", {31'd0, irq}, 32'd1);

    // R6 pending sticky
    ticks(2);
    peek(0, v); chk("R6 pending held", {31'd0, v[28]}, 32'd1);
    wrReg(0, 32'h6000_0003);
    peek(0, v); chk("R6 pending cleared by write", {31'd0, irq}, 32'd0);

    // R2 mode off: ticks ignored (count was 2)
    wrReg(0, 32'h0000_0003);
    ticks(5);
    peek(1, v); chk("R2 off mode holds count", v, 32'd2);

    // R8 one-shot, period 2, no IE
    wrReg(1, 32'd0);
    wrReg(0, 32'h8000_0002);
    ticks(5);
    peek(1, v); chk("R8 one-shot freezes", v, 32'd2);
    peek(0, v); chk("R8 no pending without IE", {31'd0, v[28]}, 32'd0);
    wrReg(0, 32'h8000_0005);
    ticks(1);
    peek(1, v); chk("R8 resume after mode write", v, 32'd3);

    // R3 tickEn low holds
    ticks(4, 1'b0);
    peek(1, v); chk("R3 no tick holds", v, 32'd3);

    // R9 / R4 continuous wrap with high count bit
    wrReg(1, 32'h0FFF_FFFE);
    wrReg(0, 32'hE000_0001);
    ticks(3);
    peek(1, v); chk("R3 step count", v, 32'h1000_0001);
    chk("R4 no early match", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R4 match ignores high bits", {31'd0, irq}, 32'd1);
    peek(1, v); chk("R9 continuous passes match", v, 32'h1000_0002);

    // R10 count write beats tick
    wrReg(1, 32'd7, 1'b1);
    peek(1, v); chk("R10 write wins over tick", v, 32'd7);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule